// File: doc/BRIEF.md
# Integer ALU with Selectable Condition-Code Update

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it may receive one operation: two operands, a 3-bit operation code and a per-operation control that decides whether the condition codes are written. The result is formed combinationally in the same cycle. A write-enable output tells the register file whether the result should be stored.

Four condition bits are kept in a register: sign, zero, signed overflow and unsigned carry or borrow. These bits change on a clock edge only when the operation is valid and asks for a flag update. The same operation code can therefore run in a plain form, which leaves the flags alone, or in a flag-setting form.

A compare runs the subtract datapath and writes the flags, but it suppresses the result write, so a later branch can test the zero bit for equality. A register copy is an add of the first operand to a forced zero. Signed and unsigned operands share one add path and one subtract path, and the two interpretations differ only in which flag is read.

Top module: `cc_alu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flags` is 4'b0000. The flag bit positions are: bit 3 sign (S), bit 2 zero (Z), bit 1 signed overflow (O), bit 0 carry/borrow (C).
- R2: For `op_sel` = 0 (add), `result` is (a + b) mod 2^W. With a flag update, C is the carry out of the top bit, and O is set when a and b have the same sign and the sign of the result differs from it.
- R3: For `op_sel` = 1 (subtract), `result` is (a - b) mod 2^W. With a flag update, C is 1 exactly when a < b as unsigned numbers, and O is set when a and b differ in sign and the sign of the result differs from the sign of a.
- R4: For `op_sel` = 2 (compare), `result` and the flags follow the subtract rules of R3, and `result_we` is 0. Z = 1 means a equals b.
- R5: The logic operations are `op_sel` = 3 and (a & b), 4 or (a | b), 5 xor (a ^ b) and 6 not (~a). With a flag update, O and C are written as 0.
- R6: For `op_sel` = 7 (move), `result` equals a, which is a + 0. With a flag update, O and C are 0.
- R7: On every flag update, S takes the top bit of `result`, and Z is 1 exactly when `result` is all zeros.
- R8: `flags` keeps its value across a clock edge unless `op_valid` and `set_cc` are both 1 at that edge.
- R9: `result_we` equals `op_valid` for every `op_sel` except 2, and it is 0 whenever `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6 not, 7 move) |
| set_cc | input | 1 | Write the condition codes at this edge |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (ignored by not and move) |
| result | output | WIDTH | Combinational operation result |
| result_we | output | 1 | Result should be written back |
| flags | output | 4 | Registered condition codes {S, Z, O, C} |

## Verification
Some cases are hard to reach from the ports. Signed overflow and unsigned carry each need operand pairs that sit right at the range boundaries. The case where a plain operation must leave flags from an earlier, different operation untouched also needs a particular order of operations. The bench uses a 4-bit configuration and sweeps every operand pair through every operation code, in both the plain and the flag-setting form. Flag-setting and plain forms alternate, so the stored flags are usually non-zero when a plain operation or an invalid cycle arrives. An all-zero flag state therefore cannot hide a wrongly taken update.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_CMP = 3'd2,
      OP_AND = 3'd3,
      OP_OR  = 3'd4,
      OP_XOR = 3'd5,
      OP_NOT = 3'd6,
      OP_MOV = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic o;
      logic c;
   } cc_flags_t;

   localparam int unsigned CC_BITS = 4;
endpackage

// File: rtl/cc_alu_arith.sv
module cc_alu_arith #(
   parameter int unsigned WIDTH        = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum,
   output logic             cy_flag,
   output logic             ov_flag
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH:0] ext;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [WIDTH-1:0] y_x;
         assign y_x = y ^ {WIDTH{do_sub}};
         assign ext = {1'b0, x} + {1'b0, y_x} + {{WIDTH{1'b0}}, do_sub};
         assign cy_flag = ext[WIDTH] ^ do_sub;
      end else begin : g_split
         logic [WIDTH:0] add_ext;
         logic [WIDTH:0] sub_ext;
         assign add_ext = {1'b0, x} + {1'b0, y};
         assign sub_ext = {1'b0, x} - {1'b0, y};
         assign ext     = do_sub ? sub_ext : add_ext;
         assign cy_flag = ext[WIDTH];
      end
   endgenerate

   assign sum = ext[WIDTH-1:0];

   always_comb begin
      if (do_sub)
         ov_flag = (x[MSB] != y[MSB]) && (sum[MSB] != x[MSB]);
      else
         ov_flag = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
   end
endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic
   import cc_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (op)
         OP_AND:  res = x & y;
         OP_OR:   res = x | y;
         OP_XOR:  res = x ^ y;
         OP_NOT:  res = ~x;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/cc_alu_flagreg.sv
module cc_alu_flagreg
   import cc_alu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  cc_flags_t d,
   output cc_flags_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= d;
   end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
   import cc_alu_pkg::*;
#(
   parameter int unsigned WIDTH        = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_sel,
   input  logic             set_cc,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic [3:0]       flags
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cc_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   logic             is_arith;
   logic             is_sub;
   logic [WIDTH-1:0] arith_b;
   logic [WIDTH-1:0] arith_sum;
   logic             arith_cy;
   logic             arith_ov;
   logic [WIDTH-1:0] logic_res;
   cc_flags_t        next_cc;
   cc_flags_t        cur_cc;

   assign op       = alu_op_e'(op_sel);
   assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
   assign is_arith = (op == OP_ADD) || is_sub || (op == OP_MOV);
   assign arith_b  = (op == OP_MOV) ? '0 : b;

   cc_alu_arith #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_arith (
      .x       (a),
      .y       (arith_b),
      .do_sub  (is_sub),
      .sum     (arith_sum),
      .cy_flag (arith_cy),
      .ov_flag (arith_ov)
   );

   cc_alu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .x   (a),
      .y   (b),
      .op  (op),
      .res (logic_res)
   );

   assign result    = is_arith ? arith_sum : logic_res;
   assign result_we = op_valid && (op != OP_CMP);

   always_comb begin
      next_cc.s = result[MSB];
      next_cc.z = (result == '0);
      next_cc.o = is_arith ? arith_ov : 1'b0;
      next_cc.c = is_arith ? arith_cy : 1'b0;
   end

   cc_alu_flagreg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (op_valid && set_cc),
      .d     (next_cc),
      .q     (cur_cc)
   );

   assign flags = cur_cc;
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
   parameter int unsigned WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_sel,
   input logic             set_cc,
   input logic [WIDTH-1:0] result,
   input logic             result_we,
   input logic [3:0]       flags
);
   logic upd;
   logic is_logic;
   assign upd      = op_valid && set_cc;
   assign is_logic = (op_sel >= 3'd3) && (op_sel <= 3'd6);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(flags));

   a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> flags[3] == $past(result[WIDTH-1]));

   a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> flags[2] == ($past(result) == '0));

   a_r5_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && is_logic) |=> flags[1:0] == 2'b00);

   a_r6_mov_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_sel == 3'd7) |=> flags[1:0] == 2'b00);

   a_r4_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd2) |-> !result_we);

   a_r9_we_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !result_we);
endmodule

bind cc_alu cc_alu_checker #(.WIDTH(WIDTH)) u_cc_alu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_sel    (op_sel),
   .set_cc    (set_cc),
   .result    (result),
   .result_we (result_we),
   .flags     (flags)
);

// File: tb/test_cc_alu.sv
module test_cc_alu;
   localparam int W = 4;
   localparam int M = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [2:0]   op_sel = 3'd0;
   logic         set_cc = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W-1:0] result;
   logic         result_we;
   logic [3:0]   flags;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cc_alu #(.WIDTH(W)) i_cc_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_sel    (op_sel),
      .set_cc    (set_cc),
      .a         (a),
      .b         (b),
      .result    (result),
      .result_we (result_we),
      .flags     (flags)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (op=%0d a=%0h b=%0h sc=%0b v=%0b)",
                  req, act, exp, op_sel, a, b, set_cc, op_valid);
      end
   endtask

   function automatic string req_of(input int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         7: return "R6";
         default: return "R5";
      endcase
   endfunction

   initial begin
      int exp_flags = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", flags, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", flags, 0);

      for (int op = 0; op < 8; op++) begin
         for (int ua = 0; ua <= M; ua++) begin
            for (int ub = 0; ub <= M; ub++) begin
               for (int sc = 0; sc < 2; sc++) begin
                  int r, c, o, s, z, ex_we;
                  bit v, a3, b3, r3;
                  v = ((ua + ub + op) % 5) != 0;
                  op_valid = v;
                  op_sel   = 3'(op);
                  set_cc   = sc[0];
                  a        = W'(ua);
                  b        = W'(ub);
                  c = 0; o = 0;
                  case (op)
                     0: begin r = (ua + ub) & M; c = (ua + ub) > M ? 1 : 0; end
                     1, 2: begin r = (ua - ub) & M; c = (ua < ub) ? 1 : 0; end
                     3: r = ua & ub;
                     4: r = ua | ub;
                     5: r = ua ^ ub;
                     6: r = (~ua) & M;
                     default: r = ua;
                  endcase
                  a3 = ua[W-1]; b3 = ub[W-1]; r3 = r[W-1];
                  if (op == 0) o = (a3 == b3 && r3 != a3) ? 1 : 0;
                  if (op == 1 || op == 2) o = (a3 != b3 && r3 != a3) ? 1 : 0;
                  s = r3 ? 1 : 0;
                  z = (r == 0) ? 1 : 0;
                  ex_we = (v && op != 2) ? 1 : 0;
                  #1;
                  check(req_of(op), result, r);
                  check(op == 2 ? "R4 no writeback" : "R9 write enable", result_we, ex_we);
                  @(posedge clk);
                  @(negedge clk);
                  if (v && sc == 1) begin
                     exp_flags = (s << 3) | (z << 2) | (o << 1) | c;
                     check(op >= 3 && op <= 6 ? "R5/R7 flags" : (op == 7 ? "R6/R7 flags" :
                           (op == 2 ? "R4/R7 flags" : (op == 1 ? "R3/R7 flags" : "R2/R7 flags"))),
                           flags, exp_flags);
                  end else begin
                     check("R8 flags held", flags, exp_flags);
                  end
               end
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule